// File: doc/BRIEF.md
# Pulse-and-Verify EPROM Programming Sequencer

This block drives the pins of a paged, byte-wide UV-erasable EPROM from a device programmer. It walks a source buffer byte by byte. Each byte gets a fixed-width active-low program pulse with the supply-mode output at programming levels. The byte is then read back and compared with the source value. Pulses repeat until the byte matches or the retry limit is used up. The device exposes only one page of its array at a time, so a page-select write that carries the page number precedes the first byte of every page.

Once every byte has programmed, the sequencer drops the supply mode to nominal levels and runs a second pass. This pass selects each page again and compares every byte with the buffer. The run ends with `done` on success. Otherwise it ends with `fail`, and `failAddr`/`failPulses` hold the byte address and the number of pulses spent on it. In the final pass that pulse count is zero.

All timing derives from one microsecond tick set by `CLK_PER_US`. Supply generation is outside the block and is represented by the `progSupply` level.

Top module: `eprom_burner`

## Requirements
- R1: After reset, `devCeN`, `devOeN` and `devPgmN` are high, `progSupply`, `devDoe`, `done` and `fail` are low.
- R2: Every program pulse (`devPgmN` low while `progSupply`=1) lasts exactly PULSE_US*CLK_PER_US+1 clocks, which lies between 95 and 105 µs with the defaults.
- R3: Address and data are unchanged for at least SETUP_US*CLK_PER_US clocks before a program pulse begins.
- R4: Every program pulse is followed by one read-back (`devOeN` falling) while `progSupply` is still 1.
- R5: The sequencer moves to the next byte on the first matching read-back, so the total pulse count equals the sum of pulses each byte needs.
- R6: A byte is given at most MAX_PULSES (25) pulses. A byte that matches on pulse 25 passes. A byte that still mismatches after pulse 25 ends the run with `fail`=1, `failAddr` = its address and `failPulses` = 25.
- R7: Before the bytes of each page, in both passes, a page-select write is issued: `devPgmN` low with `devCeN` low, `devOeN` high, `progSupply`=0, and the page number (byte address divided by PAGE_BYTES) on `devDout` bits [PW-1:0], upper bits zero.
- R8: After programming, every byte is read at `progSupply`=0 and compared with the source. The first mismatch ends the run with `fail`=1, its address in `failAddr` and `failPulses`=0.
- R9: A target byte that needs a cell changed from 0 to 1 never verifies and fails after MAX_PULSES pulses.
- R10: `done` and `fail` are never both high. Each holds, with the device pins idle as in R1, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| srcAddr | output | AW | Source buffer byte address |
| srcData | input | 8 | Source byte at `srcAddr`, combinational |
| devAddr | output | OW | Byte address within the selected page |
| devDout | output | 8 | Data driven to the device (program data or page number) |
| devDoe | output | 1 | High while `devDout` should drive the device data lines |
| devDin | input | 8 | Data read from the device |
| devCeN | output | 1 | Chip enable, active low |
| devOeN | output | 1 | Output enable, active low |
| devPgmN | output | 1 | Program / page-write strobe, active low |
| progSupply | output | 1 | 1 = programming supply levels, 0 = nominal |
| done | output | 1 | Run finished, all bytes verified |
| fail | output | 1 | Run aborted on a failing byte |
| failAddr | output | AW | Address of the failing byte |
| failPulses | output | CW | Pulses applied to the failing byte (0 in final pass) |

## Verification
A wrong page or byte counter shows at the ports as soon as the affected byte is programmed. The device model then places the data at another cell, or a page-select write carries the wrong number, and the final pass or the page-write count exposes it within one run. A pulse counter that is off by one moves the 25/26-pulse boundary, so a byte needing exactly 25 pulses fails or one needing 26 passes. A supply-mode or timer fault is seen on the first pulse: its measured width, its setup time or the supply level during its read-back is wrong.

// File: rtl/burn_pkg.sv
package burn_pkg;

  // Which duration the microsecond timer is loaded with
  typedef enum logic [1:0] {
    T_WRITE = 2'd0,
    T_SETUP = 2'd1,
    T_PULSE = 2'd2,
    T_GAP   = 2'd3
  } tsel_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic  startTimer;
    tsel_e timerSel;
    logic  clrAddr;
    logic  incAddr;
    logic  clrPulse;
    logic  incPulse;
    logic  latchFail;
    logic  pageData;
  } burnCtl_t;

endpackage

// File: rtl/burn_datapath.sv
module burn_datapath
  import burn_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int GAP_US     = 1,
  parameter int WRITE_US   = 1,
  parameter int NUM_BYTES  = 131072,
  parameter int PAGE_BYTES = 16384,
  parameter int MAX_PULSES = 25,
  localparam int AW = $clog2(NUM_BYTES),
  localparam int OW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  burnCtl_t      ctl,
  output logic [AW-1:0] srcAddr,
  input  logic [7:0]    srcData,
  output logic [OW-1:0] devAddr,
  output logic [7:0]    devDout,
  input  logic [7:0]    devDin,
  output logic          timerDone,
  output logic          isMatch,
  output logic          lastByte,
  output logic          pageEnd,
  output logic          pulseMax,
  output logic [AW-1:0] failAddr,
  output logic [CW-1:0] failPulses
);

  localparam int PW      = AW - OW;
  localparam int PREW    = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int LONG_A  = (PULSE_US > SETUP_US) ? PULSE_US : SETUP_US;
  localparam int LONG_B  = (GAP_US > WRITE_US) ? GAP_US : WRITE_US;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int USW     = $clog2(LONGEST + 1);

  // ---------------- microsecond timer ----------------
  logic [PREW-1:0] pre;
  logic [USW-1:0]  usLeft;
  logic [USW-1:0]  durSel;
  logic            tick;

  assign tick = (pre == PREW'(CLK_PER_US - 1));

  always_comb begin
    case (ctl.timerSel)
      T_WRITE: durSel = USW'(WRITE_US);
      T_SETUP: durSel = USW'(SETUP_US);
      T_PULSE: durSel = USW'(PULSE_US);
      default: durSel = USW'(GAP_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre    <= '0;
      usLeft <= '0;
    end else if (ctl.startTimer) begin
      pre    <= '0;
      usLeft <= durSel;
    end else if (usLeft != '0) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) usLeft <= usLeft - 1'b1;
    end
  end

  assign timerDone = (usLeft == '0);

  // timer only counts down between loads
  p_timer_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.startTimer |=> usLeft <= $past(usLeft));

  // ---------------- byte address and pulse count ----------------
  logic [AW-1:0] byteAddr;
  logic [CW-1:0] pulseCnt;
  logic [PW-1:0] pageNum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteAddr <= '0;
      pulseCnt <= '0;
    end else begin
      if (ctl.clrAddr)      byteAddr <= '0;
      else if (ctl.incAddr) byteAddr <= byteAddr + 1'b1;
      if (ctl.clrPulse)      pulseCnt <= '0;
      else if (ctl.incPulse) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CW'(MAX_PULSES));

  p_no_inc_at_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    pulseMax |-> !ctl.incPulse);

  assign pageNum  = byteAddr[AW-1:OW];
  assign srcAddr  = byteAddr;
  assign devAddr  = byteAddr[OW-1:0];
  assign devDout  = ctl.pageData ? 8'(pageNum) : srcData;
  assign isMatch  = (devDin == srcData);
  assign lastByte = (byteAddr == AW'(NUM_BYTES - 1));
  assign pageEnd  = &byteAddr[OW-1:0];
  assign pulseMax = (pulseCnt == CW'(MAX_PULSES));

  // ---------------- failure capture ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failAddr   <= '0;
      failPulses <= '0;
    end else if (ctl.latchFail) begin
      failAddr   <= byteAddr;
      failPulses <= pulseCnt;
    end
  end

endmodule

// File: rtl/burn_control.sv
module burn_control
  import burn_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int PULSE_US   = 100
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     timerDone,
  input  logic     isMatch,
  input  logic     lastByte,
  input  logic     pageEnd,
  input  logic     pulseMax,
  output burnCtl_t ctl,
  output logic     devCeN,
  output logic     devOeN,
  output logic     devPgmN,
  output logic     devDoe,
  output logic     progSupply,
  output logic     done,
  output logic     fail
);

  localparam int PULSE_LEN = PULSE_US * CLK_PER_US + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_PAGE, S_PGREL, S_SETUP, S_PULSE,
    S_GAP, S_CHECK, S_RDGAP, S_RDCHK
  } state_e;

  state_e state, stateNext;
  logic   finalPass, finalNext, doneNext, failNext, pageDataQ;

  // pin image per state: {ceN, oeN, pgmN, supply, doe, pageData}
  function automatic logic [5:0] pinsFor(input state_e s);
    case (s)
      S_PAGE:           return 6'b010011;
      S_PGREL:          return 6'b011011;
      S_SETUP:          return 6'b011110;
      S_PULSE:          return 6'b010110;
      S_GAP, S_CHECK:   return 6'b001100;
      S_RDGAP, S_RDCHK: return 6'b001000;
      default:          return 6'b111000;
    endcase
  endfunction

  always_comb begin
    stateNext    = state;
    finalNext    = finalPass;
    doneNext     = done;
    failNext     = fail;
    ctl          = '0;
    ctl.timerSel = T_WRITE;
    ctl.pageData = pageDataQ;
    case (state)
      S_IDLE: if (start) begin
        ctl.clrAddr    = 1'b1;
        ctl.clrPulse   = 1'b1;
        ctl.startTimer = 1'b1;
        finalNext      = 1'b0;
        doneNext       = 1'b0;
        failNext       = 1'b0;
        stateNext      = S_PAGE;
      end
      S_PAGE: if (timerDone) begin
        ctl.startTimer = 1'b1;
        stateNext      = S_PGREL;
      end
      S_PGREL: if (timerDone) begin
        ctl.startTimer = 1'b1;
        ctl.timerSel   = finalPass ? T_GAP : T_SETUP;
        stateNext      = finalPass ? S_RDGAP : S_SETUP;
      end
      S_SETUP: if (timerDone) begin
        ctl.startTimer = 1'b1;
        ctl.timerSel   = T_PULSE;
        ctl.incPulse   = 1'b1;
        stateNext      = S_PULSE;
      end
      S_PULSE: if (timerDone) begin
        ctl.startTimer = 1'b1;
        ctl.timerSel   = T_GAP;
        stateNext      = S_GAP;
      end
      S_GAP: if (timerDone) stateNext = S_CHECK;
      S_CHECK: begin
        if (isMatch) begin
          ctl.clrPulse   = 1'b1;
          ctl.startTimer = 1'b1;
          if (lastByte) begin
            ctl.clrAddr = 1'b1;
            finalNext   = 1'b1;
            stateNext   = S_PAGE;
          end else begin
            ctl.incAddr  = 1'b1;
            ctl.timerSel = pageEnd ? T_WRITE : T_SETUP;
            stateNext    = pageEnd ? S_PAGE : S_SETUP;
          end
        end else if (pulseMax) begin
          ctl.latchFail = 1'b1;
          failNext      = 1'b1;
          stateNext     = S_IDLE;
        end else begin
          ctl.startTimer = 1'b1;
          ctl.timerSel   = T_SETUP;
          stateNext      = S_SETUP;
        end
      end
      S_RDGAP: if (timerDone) stateNext = S_RDCHK;
      S_RDCHK: begin
        if (!isMatch) begin
          ctl.latchFail = 1'b1;
          failNext      = 1'b1;
          stateNext     = S_IDLE;
        end else if (lastByte) begin
          doneNext  = 1'b1;
          stateNext = S_IDLE;
        end else begin
          ctl.incAddr    = 1'b1;
          ctl.startTimer = 1'b1;
          ctl.timerSel   = pageEnd ? T_WRITE : T_GAP;
          stateNext      = pageEnd ? S_PAGE : S_RDGAP;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      finalPass <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      {devCeN, devOeN, devPgmN, progSupply, devDoe, pageDataQ} <= 6'b111000;
    end else begin
      state     <= stateNext;
      finalPass <= finalNext;
      done      <= doneNext;
      fail      <= failNext;
      {devCeN, devOeN, devPgmN, progSupply, devDoe, pageDataQ} <= pinsFor(stateNext);
    end
  end

  // ---------------- checks on the pin sequence ----------------
  int lowLen;
  always_ff @(posedge clk) begin
    if (!rstN) lowLen <= 0;
    else       lowLen <= devPgmN ? 0 : lowLen + 1;
  end

  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(devPgmN) && progSupply) |-> lowLen == PULSE_LEN);

  p_strobe_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    !devPgmN |-> (!devCeN && devOeN && devDoe));

  p_supply_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!devPgmN && $past(!devPgmN)) |-> $stable(progSupply));

  p_readback_supply_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(devPgmN) && progSupply) |=> (!devOeN && progSupply));

  p_outcome_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

endmodule

// File: rtl/eprom_burner.sv
module eprom_burner
  import burn_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int GAP_US     = 1,
  parameter int WRITE_US   = 1,
  parameter int NUM_BYTES  = 131072,
  parameter int PAGE_BYTES = 16384,
  parameter int MAX_PULSES = 25,
  localparam int AW = $clog2(NUM_BYTES),
  localparam int OW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic [AW-1:0] srcAddr,
  input  logic [7:0]    srcData,
  output logic [OW-1:0] devAddr,
  output logic [7:0]    devDout,
  output logic          devDoe,
  input  logic [7:0]    devDin,
  output logic          devCeN,
  output logic          devOeN,
  output logic          devPgmN,
  output logic          progSupply,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] failAddr,
  output logic [CW-1:0] failPulses
);

  burnCtl_t ctl;
  logic timerDone, isMatch, lastByte, pageEnd, pulseMax;

  burn_control #(
    .CLK_PER_US(CLK_PER_US),
    .PULSE_US  (PULSE_US)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerDone (timerDone),
    .isMatch   (isMatch),
    .lastByte  (lastByte),
    .pageEnd   (pageEnd),
    .pulseMax  (pulseMax),
    .ctl       (ctl),
    .devCeN    (devCeN),
    .devOeN    (devOeN),
    .devPgmN   (devPgmN),
    .devDoe    (devDoe),
    .progSupply(progSupply),
    .done      (done),
    .fail      (fail)
  );

  burn_datapath #(
    .CLK_PER_US(CLK_PER_US),
    .PULSE_US  (PULSE_US),
    .SETUP_US  (SETUP_US),
    .GAP_US    (GAP_US),
    .WRITE_US  (WRITE_US),
    .NUM_BYTES (NUM_BYTES),
    .PAGE_BYTES(PAGE_BYTES),
    .MAX_PULSES(MAX_PULSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .srcAddr   (srcAddr),
    .srcData   (srcData),
    .devAddr   (devAddr),
    .devDout   (devDout),
    .devDin    (devDin),
    .timerDone (timerDone),
    .isMatch   (isMatch),
    .lastByte  (lastByte),
    .pageEnd   (pageEnd),
    .pulseMax  (pulseMax),
    .failAddr  (failAddr),
    .failPulses(failPulses)
  );

  // address and data do not move on the edge a program pulse starts
  p_setup_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devPgmN) && progSupply) |-> ($stable(devAddr) && $stable(devDout)));

endmodule

// File: tb/eprom_burner_test.sv
module eprom_burner_test;

  localparam int CPU   = 2;
  localparam int NB    = 8;
  localparam int PB    = 4;
  localparam int NP    = NB / PB;
  localparam int MAXP  = 25;
  localparam int PUL   = 100;
  localparam int SET   = 2;

  typedef struct packed {
    int baseNeed;
    int spIdx;
    int spNeed;
    int zeroIdx;
    int corruptIdx;
    int expFail;
    int expAddr;
    int expPulses;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1, -1,  0, -1, -1, 0, 0,  0},
    '{3,  5, 25, -1, -1, 0, 0,  0},
    '{2,  6, 26, -1, -1, 1, 6, 25},
    '{1, -1,  0, -1,  2, 1, 2,  0},
    '{1, -1,  0,  1, -1, 1, 1, 25},
    '{1,  4, 25, -1, -1, 0, 0,  0},
    '{2, -1,  0, -1,  7, 1, 7,  0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, start;
  logic [2:0] srcAddr;
  logic [7:0] srcData;
  logic [1:0] devAddr;
  logic [7:0] devDout, devDin;
  logic       devDoe, devCeN, devOeN, devPgmN, progSupply, done, fail;
  logic [2:0] failAddr;
  logic [4:0] failPulses;

  eprom_burner #(
    .CLK_PER_US(CPU), .PULSE_US(PUL), .SETUP_US(SET),
    .NUM_BYTES(NB), .PAGE_BYTES(PB), .MAX_PULSES(MAXP)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcAddr(srcAddr), .srcData(srcData),
    .devAddr(devAddr), .devDout(devDout), .devDoe(devDoe), .devDin(devDin),
    .devCeN(devCeN), .devOeN(devOeN), .devPgmN(devPgmN), .progSupply(progSupply),
    .done(done), .fail(fail), .failAddr(failAddr), .failPulses(failPulses)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] srcByte(input int i);
    return 8'(8'h3C + i * 17);
  endfunction

  assign srcData = srcByte(int'(srcAddr));

  // ---------------- behavioural device model ----------------
  logic [7:0] mem  [NB];
  int         need [NB];
  int         got  [NB];
  int         pg = 0;
  int         corruptIdx = -1;
  int         pulseTotal = 0, pageWrites = 0, progReads = 0;
  int         physIdx;
  logic       prevPgm = 1'b1, prevSup = 1'b0, prevOe = 1'b1;
  logic [7:0] prevData = '0;
  logic [1:0] prevAddr = '0;
  int         lowCnt = 0, stableCnt = 0;

  assign physIdx = pg * PB + int'(devAddr);
  assign devDin  = (!devCeN && !devOeN && physIdx < NB)
                 ? (mem[physIdx] ^ ((!progSupply && physIdx == corruptIdx) ? 8'h01 : 8'h00))
                 : 8'hFF;

  always @(negedge clk) begin
    if (prevPgm && !devPgmN && progSupply)
      chk(stableCnt >= SET * CPU, "R3 setup cycles", stableCnt, SET * CPU);
    if (!devPgmN) lowCnt++;
    if (!prevPgm && devPgmN) begin
      if (prevSup) begin
        chk(lowCnt >= 95 * CPU && lowCnt <= 105 * CPU, "R2 pulse width", lowCnt, PUL * CPU + 1);
        pulseTotal++;
        if (pg * PB + int'(prevAddr) < NB) begin
          got[pg * PB + int'(prevAddr)]++;
          if (got[pg * PB + int'(prevAddr)] >= need[pg * PB + int'(prevAddr)])
            mem[pg * PB + int'(prevAddr)] &= prevData;
        end
      end else begin
        pg = int'(prevData[2:0]);
        pageWrites++;
      end
      lowCnt = 0;
    end
    if (prevOe && !devOeN && progSupply) progReads++;
    if (devAddr != prevAddr || devDout != prevData) stableCnt = 0;
    else stableCnt++;
    prevPgm  = devPgmN;
    prevSup  = progSupply;
    prevOe   = devOeN;
    prevData = devDout;
    prevAddr = devAddr;
  end

  // ---------------- one run per vector ----------------
  task automatic runVec(input vec_t v, input int k);
    int expTotal, lim, progPages, finPages;
    bit progFail;
    string tag;
    for (int i = 0; i < NB; i++) begin
      mem[i]  = (i == v.zeroIdx) ? 8'h00 : 8'hFF;
      need[i] = (i == v.spIdx) ? v.spNeed : v.baseNeed;
      got[i]  = 0;
    end
    pg = 0; corruptIdx = v.corruptIdx;
    pulseTotal = 0; pageWrites = 0; progReads = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    while (!(done || fail)) @(negedge clk);

    progFail = (v.expFail != 0) && (v.expPulses != 0);
    lim = progFail ? v.expAddr : NB;
    expTotal = progFail ? MAXP : 0;
    for (int i = 0; i < lim; i++) expTotal += need[i];
    progPages = progFail ? v.expAddr / PB + 1 : NP;
    finPages  = progFail ? 0 : ((v.expFail != 0) ? v.expAddr / PB + 1 : NP);
    if (v.zeroIdx >= 0) tag = "R9";
    else if (v.expFail != 0 && v.expPulses == 0) tag = "R8";
    else tag = "R6";

    $display("vector %0d finished", k);
    chk(fail == (v.expFail != 0), {tag, " fail flag"}, int'(fail), v.expFail);
    chk(done == (v.expFail == 0), "R10 done flag", int'(done), int'(v.expFail == 0));
    if (v.expFail != 0) begin
      chk(int'(failAddr) == v.expAddr, {tag, " fail address"}, int'(failAddr), v.expAddr);
      chk(int'(failPulses) == v.expPulses, {tag, " fail pulse count"}, int'(failPulses), v.expPulses);
    end
    chk(pulseTotal == expTotal, "R5 total pulses", pulseTotal, expTotal);
    chk(progReads == expTotal, "R4 read-backs at programming supply", progReads, expTotal);
    chk(pageWrites == progPages + finPages, "R7 page-select writes", pageWrites, progPages + finPages);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; need[i] = 1; got[i] = 0; end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({devCeN, devOeN, devPgmN} == 3'b111, "R1 control pins idle", int'({devCeN, devOeN, devPgmN}), 7);
    chk(!progSupply && !devDoe, "R1 supply and drive off", int'({progSupply, devDoe}), 0);
    chk(!done && !fail, "R1 outcome flags clear", int'({done, fail}), 0);

    // R1 reset in the middle of a page-select write returns pins to idle
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(!devPgmN && !progSupply && devDoe && devDout[2:0] == 3'd0, "R7 first page write", int'(devDout), 0);
    #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk({devCeN, devOeN, devPgmN, progSupply} == 4'b1110, "R1 pins after reset", int'({devCeN, devOeN, devPgmN, progSupply}), 14);
    repeat (3) @(negedge clk);

    // vector table
    for (int k = 0; k < 7; k++) runVec(VECS[k], k);

    // R10: outcome holds with pins idle
    repeat (20) @(negedge clk);
    chk(fail && !done, "R10 fail held", int'({done, fail}), 1);
    chk({devCeN, devOeN, devPgmN, progSupply} == 4'b1110, "R10 pins idle after run", int'({devCeN, devOeN, devPgmN, progSupply}), 14);
    runVec(VECS[0], 7);
    repeat (20) @(negedge clk);
    chk(done && !fail, "R10 done held", int'({done, fail}), 2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule